// File: doc/BRIEF.md
# Triggerable Circular Pipeline Address Manager

This block holds the pointer logic for a circular sample pipeline. The analog storage itself is outside the block. Each pipeline advance stores the current sample in the slot under the write pointer, and the write pointer then moves to the next slot that is not held. A trigger pointer follows behind at a programmable distance, counted in writes. A trigger marks the slot under the trigger pointer as held and appends that slot's address to a short ordered queue. A held slot keeps its data until a release command frees the oldest held slot, which the readout logic issues after the slot has been read.

The readout side uses the queued addresses, oldest first, to pick which slots to digitise. Acquisition logic drives the advance and trigger inputs from the bunch timing. The queue depth caps the number of held slots. A trigger that finds the queue full is lost, and a sticky flag records the loss.

Top module: `pl_addr_mgr`

## Requirements
- R1: After `rst`, `wr_addr` is 0, `q_count` is 0, `overflow` is 0 and every field of `q_addrs` is 0.
- R2: With no slot held, each cycle with `pipe_adv` high moves `wr_addr` to the next index, and index 47 wraps to 0.
- R3: An accepted trigger appends the address of the slot written L writes earlier (L=1 is the most recent write) at queue position `q_count`, then raises `q_count` by one. Entry k sits at `q_addrs[6k+5:6k]`, entry 0 is the oldest, and entries at or above `q_count` read 0.
- R4: Whenever the write pointer moves, it passes over every held slot and lands on the next free slot in circular order.
- R5: Only actual writes count toward the latency, so slots passed over do not shift the trigger pointer.
- R6: A trigger is dropped when the queue holds 4 entries, counted after any release in the same cycle. A dropped trigger sets `overflow`, which stays set until `rst` or `pipe_rst`.
- R7: A trigger has no effect if its slot is already held (judged before any same-cycle release) or if fewer than L writes have occurred since the last reset.
- R8: `rel_req` removes the oldest entry and shifts the others toward entry 0, and the freed slot becomes writable again. `rel_req` with an empty queue changes nothing.
- R9: A latency input of 0 acts as 1, and any value above 47 acts as 47.
- R10: `pipe_rst` has priority over all other inputs and returns every output to the R1 state, including `overflow`.
- R11: All outputs change only at the rising clock edge that samples the inputs, never before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pipe_rst | input | 1 | Pipeline clear: pointers, queue, holds and flag |
| pipe_adv | input | 1 | Pipeline advance: write the current slot and step |
| trig | input | 1 | Hold the slot under the trigger pointer |
| rel_req | input | 1 | Free the oldest held slot |
| lat_in | input | 6 | Trigger latency in writes (clamped to 1..47) |
| wr_addr | output | 6 | Slot the next advance writes |
| q_addrs | output | 24 | Held slot addresses, entry k at bits 6k+5:6k, oldest at entry 0 |
| q_count | output | 3 | Number of held slots (0..4) |
| overflow | output | 1 | Sticky: a trigger was lost to a full queue |

## Verification
Every result of this block is registered. The inputs sampled at one rising edge are visible on `wr_addr`, `q_addrs`, `q_count` and `overflow` immediately after that edge, and one cycle of latency applies to all four. The bench changes inputs only on the falling edge and compares outputs 1 ns after the rising edge. In one directed step it also looks at the outputs just before the edge, to confirm that an advance has not moved anything early. Expected trigger addresses follow the write history. The bench keeps its own record of written slots, so that skipped slots and the latency clamp produce the predicted address.

// File: rtl/pl_pkg.sv
package pl_pkg;

    parameter int SLOTS  = 48;
    parameter int QDEPTH = 4;
    parameter int AW     = $clog2(SLOTS);
    parameter int CW     = $clog2(QDEPTH + 1);

    typedef logic [AW-1:0]         slot_t;
    typedef logic [CW-1:0]         cnt_t;
    typedef slot_t [QDEPTH-1:0]    qarr_t;
    typedef logic [SLOTS-1:0]      smap_t;

    typedef struct packed {
        logic adv;
        logic trig;
        logic rel;
        logic clr;
    } ctl_t;

    localparam cnt_t  QFULL   = cnt_t'(QDEPTH);
    localparam slot_t LAT_MAX = slot_t'(SLOTS - 1);

    function automatic slot_t slot_inc(slot_t s);
        return (int'(s) == SLOTS - 1) ? '0 : s + slot_t'(1);
    endfunction

    function automatic slot_t clamp_lat(slot_t l);
        if (l == '0)
            return slot_t'(1);
        if (int'(l) > SLOTS - 1)
            return LAT_MAX;
        return l;
    endfunction

    function automatic slot_t back_index(slot_t wc, slot_t l);
        int d;
        d = int'(wc) - int'(l);
        if (d < 0)
            d = d + SLOTS;
        return slot_t'(d);
    endfunction

    function automatic smap_t held_map(qarr_t q, cnt_t c);
        smap_t m;
        m = '0;
        for (int k = 0; k < QDEPTH; k++)
            if (k < int'(c))
                m[q[k]] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/pl_hist.sv
module pl_hist
    import pl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  wr_en,
    input  slot_t wr_slot,
    input  slot_t lat_raw,
    output slot_t tp,
    output logic  tp_ok
);

    slot_t            hist [SLOTS];
    logic [SLOTS-1:0] hv;
    slot_t            wc;
    slot_t            lat;
    slot_t            idx;

    always_comb begin
        lat   = clamp_lat(lat_raw);
        idx   = back_index(wc, lat);
        tp    = hist[idx];
        tp_ok = hv[idx];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wc <= '0;
            hv <= '0;
            for (int i = 0; i < SLOTS; i++)
                hist[i] <= '0;
        end else if (wr_en) begin
            hist[wc] <= wr_slot;
            hv[wc]   <= 1'b1;
            wc       <= slot_inc(wc);
        end
    end

    // R9: effective latency always inside 1..SLOTS-1
    always_comb begin
        a_r9_lat_range: assert (rst || (lat != '0 && int'(lat) <= SLOTS - 1));
    end

endmodule

// File: rtl/pl_trig_queue.sv
module pl_trig_queue
    import pl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  ctl,
    input  slot_t tp,
    input  logic  tp_ok,
    output qarr_t q,
    output cnt_t  cnt,
    output logic  ovf,
    output smap_t held,
    output smap_t held_nx
);

    qarr_t q_n;
    cnt_t  c_n;
    logic  o_n;
    logic  hit;
    logic  want;

    always_comb begin
        q_n  = q;
        c_n  = cnt;
        o_n  = ovf;
        hit  = held[tp];
        want = ctl.trig && tp_ok && !hit;

        if (ctl.rel && cnt != '0) begin
            for (int i = 0; i < QDEPTH - 1; i++)
                q_n[i] = q[i+1];
            q_n[QDEPTH-1] = '0;
            c_n = cnt - cnt_t'(1);
        end

        if (want) begin
            if (c_n == QFULL) begin
                o_n = 1'b1;
            end else begin
                for (int i = 0; i < QDEPTH; i++)
                    if (cnt_t'(i) == c_n)
                        q_n[i] = tp;
                c_n = c_n + cnt_t'(1);
            end
        end

        if (ctl.clr) begin
            q_n = '0;
            c_n = '0;
            o_n = 1'b0;
        end
    end

    assign held    = held_map(q, cnt);
    assign held_nx = held_map(q_n, c_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            q   <= q_n;
            cnt <= c_n;
            ovf <= o_n;
        end
    end

    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= QFULL);

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ctl.clr) |=> ovf);

    a_r8_pop_one: assert property (@(posedge clk) disable iff (rst)
        (ctl.rel && cnt != '0 && !ctl.trig && !ctl.clr) |=> cnt == $past(cnt) - cnt_t'(1));

    a_r7_held_no_push: assert property (@(posedge clk) disable iff (rst)
        (ctl.trig && held[tp] && !ctl.rel && !ctl.clr) |=> cnt == $past(cnt));

endmodule

// File: rtl/pl_wr_ptr.sv
module pl_wr_ptr
    import pl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  adv,
    input  smap_t held,
    input  smap_t held_nx,
    output slot_t wp,
    output logic  wr_en
);

    slot_t nx;
    logic  found;

    assign wr_en = adv && !clr && !held_nx[wp];

    always_comb begin
        nx    = wp;
        found = 1'b0;
        for (int i = 1; i < SLOTS; i++) begin
            int c;
            c = int'(wp) + i;
            if (c >= SLOTS)
                c = c - SLOTS;
            if (!found && !held_nx[c]) begin
                nx    = slot_t'(c);
                found = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            wp <= '0;
        else if (adv)
            wp <= nx;
    end

    // R4: after a move the pointer rests on a free slot
    a_r4_lands_free: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && $countones(held_nx) < SLOTS - 1) |=> !held[wp]);

    a_r2_in_range: assert property (@(posedge clk) disable iff (rst)
        int'(wp) < SLOTS);

endmodule

// File: rtl/pl_addr_mgr.sv
module pl_addr_mgr
    import pl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pipe_rst,
    input  logic                 pipe_adv,
    input  logic                 trig,
    input  logic                 rel_req,
    input  logic [AW-1:0]        lat_in,
    output logic [AW-1:0]        wr_addr,
    output logic [QDEPTH*AW-1:0] q_addrs,
    output logic [CW-1:0]        q_count,
    output logic                 overflow
);

    ctl_t  ctl;
    slot_t tp;
    logic  tp_ok;
    logic  wr_en;
    slot_t wp;
    qarr_t q;
    cnt_t  cnt;
    logic  ovf;
    smap_t held;
    smap_t held_nx;

    assign ctl = '{adv: pipe_adv, trig: trig, rel: rel_req, clr: pipe_rst};

    pl_hist u_hist (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctl.clr),
        .wr_en   (wr_en),
        .wr_slot (wp),
        .lat_raw (lat_in),
        .tp      (tp),
        .tp_ok   (tp_ok)
    );

    pl_trig_queue u_queue (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .tp      (tp),
        .tp_ok   (tp_ok),
        .q       (q),
        .cnt     (cnt),
        .ovf     (ovf),
        .held    (held),
        .held_nx (held_nx)
    );

    pl_wr_ptr u_wptr (
        .clk     (clk),
        .rst     (rst),
        .clr     (ctl.clr),
        .adv     (ctl.adv),
        .held    (held),
        .held_nx (held_nx),
        .wp      (wp),
        .wr_en   (wr_en)
    );

    assign wr_addr  = wp;
    assign q_addrs  = q;
    assign q_count  = cnt;
    assign overflow = ovf;

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        pipe_rst |=> (wr_addr == '0 && q_count == '0 && !overflow && q_addrs == '0));

    a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!pipe_rst && !pipe_adv && !trig && !rel_req) |=> $stable(wr_addr) && $stable(q_count));

endmodule

// File: tb/pl_addr_mgr_tb.sv
`timescale 1ns/1ps
module pl_addr_mgr_tb;
    import pl_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        pipe_rst, pipe_adv, trig, rel_req;
    logic [5:0]  lat_in;
    logic [5:0]  wr_addr;
    logic [23:0] q_addrs;
    logic [2:0]  q_count;
    logic        overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // behavioural record of the pipeline
    int m_q [4];
    int m_cnt, m_wp, m_wc;
    bit m_ovf;
    int m_hist [48];
    bit m_hv [48];

    always #2 clk = ~clk;

    pl_addr_mgr u_dut (
        .clk(clk), .rst(rst), .pipe_rst(pipe_rst), .pipe_adv(pipe_adv),
        .trig(trig), .rel_req(rel_req), .lat_in(lat_in),
        .wr_addr(wr_addr), .q_addrs(q_addrs), .q_count(q_count), .overflow(overflow)
    );

    function automatic bit m_held(int s);
        for (int k = 0; k < m_cnt; k++)
            if (m_q[k] == s) return 1'b1;
        return 1'b0;
    endfunction

    task automatic m_clear();
        for (int k = 0; k < 4; k++) m_q[k] = 0;
        for (int k = 0; k < 48; k++) begin m_hist[k] = 0; m_hv[k] = 1'b0; end
        m_cnt = 0; m_wp = 0; m_wc = 0; m_ovf = 1'b0;
    endtask

    task automatic m_step(bit a, bit t, bit r, bit c, int l);
        int le, idx, tp, nx;
        bit ok, hit;
        if (c) begin
            m_clear();
            return;
        end
        le  = (l == 0) ? 1 : ((l > 47) ? 47 : l);
        idx = m_wc - le;
        if (idx < 0) idx += 48;
        tp  = m_hist[idx];
        ok  = m_hv[idx];
        hit = m_held(tp);
        if (r && m_cnt > 0) begin
            for (int k = 0; k < 3; k++) m_q[k] = m_q[k+1];
            m_q[3] = 0;
            m_cnt--;
        end
        if (t && ok && !hit) begin
            if (m_cnt == 4) m_ovf = 1'b1;
            else begin m_q[m_cnt] = tp; m_cnt++; end
        end
        if (a) begin
            if (!m_held(m_wp)) begin
                m_hist[m_wc] = m_wp;
                m_hv[m_wc]   = 1'b1;
                m_wc = (m_wc + 1) % 48;
            end
            nx = m_wp;
            for (int i = 1; i < 48; i++) begin
                if (!m_held((m_wp + i) % 48)) begin
                    nx = (m_wp + i) % 48;
                    break;
                end
            end
            m_wp = nx;
        end
    endtask

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    task automatic step(bit a, bit t, bit r, bit c, int l);
        @(negedge clk);
        pipe_adv = a; trig = t; rel_req = r; pipe_rst = c; lat_in = 6'(l);
        m_step(a, t, r, c, l);
        @(posedge clk);
        #1;
        pipe_adv = 1'b0; trig = 1'b0; rel_req = 1'b0; pipe_rst = 1'b0;
    endtask

    task automatic advance(int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 1);
    endtask

    function automatic int qe(int k);
        return int'(q_addrs[k*6 +: 6]);
    endfunction

    task automatic check_model(string tag);
        check({tag, " wr_addr"}, int'(wr_addr), m_wp);
        check({tag, " q_count"}, int'(q_count), m_cnt);
        check({tag, " overflow"}, int'(overflow), int'(m_ovf));
        for (int k = 0; k < 4; k++)
            check({tag, " entry"}, qe(k), m_q[k]);
    endtask

    // stimulus table: {adv, trig, rel, lat[5:0]}
    localparam logic [8:0] VEC [24] = '{
        {1'b1,1'b0,1'b0,6'd3},  {1'b1,1'b0,1'b0,6'd3},  {1'b1,1'b1,1'b0,6'd2},
        {1'b1,1'b0,1'b0,6'd1},  {1'b0,1'b1,1'b0,6'd1},  {1'b1,1'b1,1'b0,6'd5},
        {1'b1,1'b0,1'b0,6'd0},  {1'b0,1'b1,1'b0,6'd0},  {1'b1,1'b1,1'b0,6'd9},
        {1'b1,1'b1,1'b0,6'd4},  {1'b1,1'b1,1'b0,6'd6},  {1'b0,1'b0,1'b1,6'd1},
        {1'b1,1'b1,1'b1,6'd2},  {1'b1,1'b0,1'b0,6'd63}, {1'b1,1'b1,1'b0,6'd63},
        {1'b0,1'b0,1'b1,6'd7},  {1'b1,1'b0,1'b1,6'd7},  {1'b1,1'b1,1'b0,6'd47},
        {1'b1,1'b1,1'b0,6'd12}, {1'b0,1'b1,1'b1,6'd1},  {1'b1,1'b0,1'b0,6'd20},
        {1'b1,1'b0,1'b1,6'd20}, {1'b1,1'b1,1'b0,6'd3},  {1'b0,1'b0,1'b1,6'd3}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired before completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pipe_rst = 1'b0; pipe_adv = 1'b0; trig = 1'b0; rel_req = 1'b0; lat_in = 6'd1;
        m_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 wr_addr", int'(wr_addr), 0);
        check("R1 q_count", int'(q_count), 0);
        check("R1 overflow", int'(overflow), 0);
        check("R1 q_addrs", int'(q_addrs), 0);

        // R7 trigger before L writes is ignored
        advance(2);
        step(1'b0, 1'b1, 1'b0, 1'b0, 3);
        check("R7 early trigger count", int'(q_count), 0);

        // R11 nothing moves before the edge
        @(negedge clk);
        pipe_adv = 1'b1;
        m_step(1'b1, 1'b0, 1'b0, 1'b0, 1);
        #1;
        check("R11 pre-edge wr_addr", int'(wr_addr), 2);
        @(posedge clk);
        #1;
        pipe_adv = 1'b0;
        check("R11 post-edge wr_addr", int'(wr_addr), 3);

        // R2 plain advance
        advance(7);
        check("R2 wr_addr after 10", int'(wr_addr), 10);

        // R3 trigger latency 3 -> slot 7
        step(1'b0, 1'b1, 1'b0, 1'b0, 3);
        check("R3 count", int'(q_count), 1);
        check("R3 entry0", qe(0), 7);
        check("R3 entry1 empty", qe(1), 0);

        // R2 wrap, R4 skip over slot 7
        advance(37);
        check("R2 wr_addr at 47", int'(wr_addr), 47);
        advance(1);
        check("R2 wrap to 0", int'(wr_addr), 0);
        advance(7);
        check("R4 skip held slot", int'(wr_addr), 8);

        // R5 skipped slot not counted toward latency
        advance(1);
        step(1'b0, 1'b1, 1'b0, 1'b0, 2);
        check("R5 count", int'(q_count), 2);
        check("R5 entry1", qe(1), 6);

        // R7 already-held slot ignored
        step(1'b0, 1'b1, 1'b0, 1'b0, 2);
        check("R7 held slot count", int'(q_count), 2);

        step(1'b0, 1'b1, 1'b0, 1'b0, 1);
        check("R3 entry2", qe(2), 8);
        advance(1);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1);
        check("R3 entry3", qe(3), 9);
        check("R3 full count", int'(q_count), 4);

        // R6 drop when full
        advance(1);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1);
        check("R6 overflow set", int'(overflow), 1);
        check("R6 count stays", int'(q_count), 4);
        check("R6 entry3 kept", qe(3), 9);

        // R8 release oldest
        step(1'b0, 1'b0, 1'b1, 1'b0, 1);
        check("R8 count", int'(q_count), 3);
        check("R8 shifted entry0", qe(0), 6);
        check("R8 vacated entry3", qe(3), 0);
        check("R6 overflow sticky", int'(overflow), 1);
        advance(43);
        check("R8 freed slot written", int'(wr_addr), 7);

        // R9 latency clamp
        step(1'b0, 1'b0, 1'b1, 1'b0, 1);
        step(1'b0, 1'b1, 1'b0, 1'b0, 0);
        check("R9 lat0 entry2", qe(2), 5);
        step(1'b0, 1'b1, 1'b0, 1'b0, 63);
        check("R9 lat63 entry3", qe(3), 6);

        // R6 release counts first when full
        step(1'b0, 1'b1, 1'b1, 1'b0, 2);
        check("R6 release-then-push count", int'(q_count), 4);
        check("R6 release-then-push entry3", qe(3), 4);
        check("R6 release-then-push entry0", qe(0), 9);

        // R10 pipeline clear has priority
        step(1'b1, 1'b1, 1'b1, 1'b1, 1);
        check("R10 wr_addr", int'(wr_addr), 0);
        check("R10 q_count", int'(q_count), 0);
        check("R10 overflow", int'(overflow), 0);
        check("R10 q_addrs", int'(q_addrs), 0);

        // R8 release on empty queue
        step(1'b0, 1'b0, 1'b1, 1'b0, 1);
        check("R8 empty release count", int'(q_count), 0);
        check("R8 empty release wr_addr", int'(wr_addr), 0);
        advance(1);
        check("R2 after clear", int'(wr_addr), 1);

        // table walk against the behavioural record (R3 R4 R5 R6 R7 R8 R9)
        for (int p = 0; p < 8; p++) begin
            for (int v = 0; v < 24; v++) begin
                step(VEC[v][8], VEC[v][7], VEC[v][6], 1'b0, int'(VEC[v][5:0]));
                check_model("R4/R5 table");
            end
            advance(5 + p);
            check_model("R2 table advance");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule